// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master from a fast functional clock. A programmable divider first derives a slower internal tick rate. Two separately programmed counts then set how many internal ticks the clock spends low and how many it spends high. A fixed trim, set by parameter for each phase, is added to each count. Software picks the three values: the divider, the low count and the high count. A 100 kHz target usually uses equal low and high counts. Faster targets usually use an uneven split, with the high phase near one third of the period.

The three values are written through a small write port. A write lands only while the generator is disabled, so a running clock can never change shape partway through. A range check flags any value of zero, and while that flag is low the generator stays idle. Once enabled with a valid setting, the generator starts with a low phase. At the end of each low phase it releases the line. It then waits until the line, seen through a synchronizer, reads back high. This lets a slave stretch the clock. Only then does it count the high phase. A one-cycle strobe marks the end of every counted phase.

Top module: `scl_timing_gen`

## Requirements
- R1: During and right after reset, `scl_o` is 1, `tick` is 0 and `cfg_ok` is 0, because all three settings reset to zero.
- R2: When `wr_en` is 1 and `enable` is 0 at a clock edge, `wr_data` is stored in the setting chosen by `wr_sel`: 0 selects the divider, 1 the low count, 2 the high count. The code 3 selects nothing and changes no setting.
- R3: A write made while `enable` is 1 changes no setting. The clock shape keeps the values that were stored before enabling.
- R4: `cfg_ok` is 1 only when the divider, the low count and the high count are all nonzero. While it is 0, `enable` has no effect: `scl_o` stays 1 and `tick` stays 0.
- R5: Each low phase of `scl_o` lasts exactly (LOW + TRIM_LO) * (DIV + 1) clock cycles.
- R6: After `scl_o` is released, high-phase counting starts only once `scl_in` has been seen high through SYNC_STAGES flops. With `scl_in` held low for S cycles after the release, each high level of `scl_o` lasts S + SYNC_STAGES + 1 + (HIGH + TRIM_HI) * (DIV + 1) cycles.
- R7: When `enable` rises with a valid setting, `scl_o` goes low on the next clock edge. The first low phase has its full length.
- R8: `tick` is a one-cycle pulse in the first cycle after each counted phase ends, and so it comes with every edge of `scl_o` caused by counting. Enabling and disabling the block give no `tick`.
- R9: Clearing `enable` returns `scl_o` to 1 on the next clock edge and resets the counters. The next enable begins a complete low phase.
- R10: The largest settings (255 for each value) give exact phase lengths, with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the generator; settings are frozen while high |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select: 0 divider, 1 low count, 2 high count, 3 none |
| wr_data | input | CNT_W | Value to store |
| scl_in | input | 1 | Level of the clock line as read back from the bus |
| scl_o | output | 1 | Clock drive: 0 pulls low, 1 releases |
| tick | output | 1 | One-cycle strobe at the end of each counted phase |
| cfg_ok | output | 1 | All three settings are nonzero |

## Verification
The bench builds the block with CNT_W = 8, TRIM_LO = 2, TRIM_HI = 1 and SYNC_STAGES = 2. The small trims keep phases to a few dozen cycles, so many periods fit in a short run and each trim stays separately visible in the measured lengths. The full 8-bit width still allows the divider and both counts to be driven to 255, so the widest length sums are covered. A bench-side line model holds `scl_in` low for a chosen number of cycles, which brings the synchronizer delay and slave stretching into the measured high levels.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  localparam logic [1:0] SEL_DIV  = 2'd0;
  localparam logic [1:0] SEL_LOW  = 2'd1;
  localparam logic [1:0] SEL_HIGH = 2'd2;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] div_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] high_q,
  output logic             valid
);
  import scl_timing_pkg::*;

  logic             wr_ok;
  logic [CNT_W-1:0] div_d, low_d, high_d;

  assign wr_ok = wr_en && !enable;

  always_comb begin
    div_d  = div_q;
    low_d  = low_q;
    high_d = high_q;
    if (wr_ok) begin
      case (wr_sel)
        SEL_DIV:  div_d  = wr_data;
        SEL_LOW:  low_d  = wr_data;
        SEL_HIGH: high_d = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (wr_ok) begin
      div_q  <= div_d;
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  assign valid = (div_q != '0) && (low_q != '0) && (high_q != '0);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(div_q) && $stable(low_q) && $stable(high_q))); // R3
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] div,
  output logic             strobe
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe = run && wrap;

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div)); // R5
endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sh_d = d;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int CNT_W   = 8,
  parameter int TRIM_LO = 7,
  parameter int TRIM_HI = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             istb,
  input  logic             scl_seen,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic             div_run,
  output logic             scl_o,
  output logic             tick
);
  import scl_timing_pkg::*;

  localparam int LW = CNT_W + 2;

  phase_e       st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] lo_last, hi_last;
  logic          end_d;

  assign lo_last = LW'(low_cnt)  + LW'(TRIM_LO) - LW'(1);
  assign hi_last = LW'(high_cnt) + LW'(TRIM_HI) - LW'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    end_d = 1'b0;
    if (!run) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          st_d  = PH_LOW;
          cnt_d = '0;
        end
        PH_LOW: begin
          if (istb) begin
            if (cnt_q == lo_last) begin
              st_d  = PH_WAIT;
              cnt_d = '0;
              end_d = 1'b1;
            end else begin
              cnt_d = cnt_q + LW'(1);
            end
          end
        end
        PH_WAIT: begin
          if (scl_seen) begin
            st_d  = PH_HIGH;
            cnt_d = '0;
          end
        end
        PH_HIGH: begin
          if (istb) begin
            if (cnt_q == hi_last) begin
              st_d  = PH_LOW;
              cnt_d = '0;
              end_d = 1'b1;
            end else begin
              cnt_d = cnt_q + LW'(1);
            end
          end
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tick  <= end_d;
    end
  end

  assign div_run = (st_q == PH_LOW) || (st_q == PH_HIGH);
  assign scl_o   = (st_q != PH_LOW);

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R8
  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !tick)); // R9
  AST_LOW_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW && run && !istb) |=> (st_q == PH_LOW)); // R5
  AST_LOW_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW) |-> (cnt_q <= lo_last)); // R10
  AST_HIGH_WAITS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_WAIT && !scl_seen) |=> (st_q != PH_HIGH)); // R6
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W       = 8,
  parameter int TRIM_LO     = 7,
  parameter int TRIM_HI     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             tick,
  output logic             cfg_ok
);
  logic             rst_s_n;
  logic [CNT_W-1:0] div_v, low_v, high_v;
  logic             run, div_run, istb, scl_seen;

  scl_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  scl_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .enable  (enable),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .div_q   (div_v),
    .low_q   (low_v),
    .high_q  (high_v),
    .valid   (cfg_ok)
  );

  assign run = enable && cfg_ok;

  scl_prescaler #(.CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run    (div_run),
    .div    (div_v),
    .strobe (istb)
  );

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (scl_in),
    .q     (scl_seen)
  );

  scl_phase_fsm #(.CNT_W(CNT_W), .TRIM_LO(TRIM_LO), .TRIM_HI(TRIM_HI)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (run),
    .istb     (istb),
    .scl_seen (scl_seen),
    .low_cnt  (low_v),
    .high_cnt (high_v),
    .div_run  (div_run),
    .scl_o    (scl_o),
    .tick     (tick)
  );

  AST_BAD_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cfg_ok |-> (scl_o && !tick)); // R4
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int CW = 8;
  localparam int TL = 2;
  localparam int TH = 1;
  localparam int SY = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [CW-1:0] wr_data = '0;
  logic          scl_in = 1'b1;
  logic          scl_o, tick, cfg_ok;

  int n_chk = 0;
  int n_bad = 0;
  int exp_len[$];
  bit exp_lvl[$];
  bit mon_go = 1'b0;
  bit seen_low = 1'b0;
  bit mon_prev = 1'b1;
  int run_len = 0;
  int stretch_cyc = 0;
  int hold = 0;
  bit line_prev = 1'b1;

  scl_timing_gen #(.CNT_W(CW), .TRIM_LO(TL), .TRIM_HI(TH), .SYNC_STAGES(SY)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .scl_in(scl_in), .scl_o(scl_o), .tick(tick), .cfg_ok(cfg_ok)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // bus line model with optional slave stretching
  always @(negedge clk) begin
    if (scl_o && !line_prev) hold = stretch_cyc;
    scl_in = scl_o && (hold == 0);
    if (hold > 0) hold--;
    line_prev = scl_o;
  end

  // monitor: measures scl_o levels and compares against the scoreboard
  always @(negedge clk) begin
    if (mon_go) begin
      bit chg;
      chg = (scl_o !== mon_prev);
      if (seen_low) begin
        if (chg) begin
          check("R8 tick at phase end", int'(tick), 1);
          if (exp_len.size() > 0) begin
            bit lv;
            int ln;
            lv = exp_lvl.pop_front();
            ln = exp_len.pop_front();
            check(lv ? "R6 high level length" : "R5 low level length", run_len, ln);
            check("R5 level order", int'(mon_prev), int'(lv));
          end
        end else if (tick) begin
          check("R8 tick without phase end", 1, 0);
        end
      end
      if (chg) begin
        if (scl_o == 1'b0) seen_low = 1'b1;
        run_len = 1;
      end else begin
        run_len++;
      end
      mon_prev = scl_o;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = CW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_case(input int p, input int lo, input int hi, input int s,
                          input int pairs, input bit poke);
    cfg_write(2'd0, p);
    cfg_write(2'd1, lo);
    cfg_write(2'd2, hi);
    if (poke) cfg_write(2'd3, 0); // R2: select 3 stores nothing
    @(negedge clk);
    check("R2 cfg_ok after writes", int'(cfg_ok), 1);
    stretch_cyc = s;
    for (int i = 0; i < pairs; i++) begin
      exp_lvl.push_back(1'b0); exp_len.push_back((lo + TL) * (p + 1));
      exp_lvl.push_back(1'b1); exp_len.push_back(s + SY + 1 + (hi + TH) * (p + 1));
    end
    enable = 1'b1;
    @(negedge clk);
    check("R7 low right after enable", int'(scl_o), 0);
    if (poke) begin
      // R3: writes while enabled must not reshape the clock
      cfg_write(2'd0, 0);
      cfg_write(2'd1, 200);
      cfg_write(2'd2, 0);
      check("R3 cfg_ok unchanged", int'(cfg_ok), 1);
    end
    while (exp_len.size() > 0) @(negedge clk);
    enable = 1'b0;
    seen_low = 1'b0;
    @(negedge clk);
    check("R9 released after disable", int'(scl_o), 1);
    repeat (6) @(negedge clk);
    stretch_cyc = 0;
  endtask

  task automatic bad_case(input int p, input int lo, input int hi);
    int seen_bad;
    cfg_write(2'd0, p);
    cfg_write(2'd1, lo);
    cfg_write(2'd2, hi);
    @(negedge clk);
    check("R4 cfg_ok low for zero value", int'(cfg_ok), 0);
    enable = 1'b1;
    seen_bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!scl_o || tick) seen_bad++;
    end
    check("R4 enable ignored with bad setting", seen_bad, 0);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 scl_o in reset", int'(scl_o), 1);
    check("R1 tick in reset", int'(tick), 0);
    check("R1 cfg_ok in reset", int'(cfg_ok), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 scl_o after reset", int'(scl_o), 1);
    check("R1 cfg_ok after reset", int'(cfg_ok), 0);
    mon_prev = scl_o;
    mon_go = 1'b1;

    // standard-like symmetric setting
    run_case(1, 4, 4, 0, 3, 1'b0);
    // uneven split, larger divider
    run_case(3, 6, 2, 0, 2, 1'b0);
    // slave stretching
    run_case(1, 3, 3, 5, 2, 1'b0);
    // writes while running and null select
    run_case(2, 5, 3, 0, 2, 1'b1);
    // R3: the values poked while enabled were dropped; re-run stored setting
    cfg_write(2'd3, 9);
    @(negedge clk);
    check("R3 setting kept after disable", int'(cfg_ok), 1);
    run_case(2, 5, 3, 0, 1, 1'b0);
    // R10 extremes
    run_case(255, 1, 1, 0, 1, 1'b0);
    run_case(1, 255, 255, 0, 1, 1'b0);
    // minimum counts
    run_case(1, 1, 1, 0, 2, 1'b0);
    // R4: each zero setting blocks the clock
    bad_case(0, 4, 4);
    bad_case(1, 0, 4);
    bad_case(1, 4, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule